// File: doc/BRIEF.md
# Dual-Winding Peak-Current Chopper

This block sets the on-time of two motor windings by chopping at a fixed period of 256 clocks. Both windings switch on together when a period begins. Each winding has its own current-sense comparator bit, and the winding switches off when that bit reports that its current has reached the reference. The winding then stays off until the next period begins. A programmable blanking count masks the comparator bits at the start of each period, so that switching spikes cannot end the on-time early. The analog comparators and the reference generators are outside the block. Only their one-bit results arrive here, and they pass through a two-flop synchroniser first.

A select bit for each winding chooses how the off-time is applied to the bridge. In fast decay the phase legs keep the values from the step sequencer and the winding's active-low inhibit line carries the chopping. In slow decay the inhibit line stays high and the winding's two phase legs carry the chopping. An active-low sync pulse marks the start of each period, for use by external slope compensation. A disable input drives every bridge output low.

Top module: `dual_chop_top`

## Requirements
- R1: The period counter runs from reset with no gaps and repeats every 256 clock cycles. Successive falling edges of `sync_n` are 256 cycles apart.
- R2: At period count 0 both windings are on. This holds even when both comparator bits are already high. After that, each winding turns off only on its own comparator bit.
- R3: A winding that has turned off stays off for all remaining counts of the period. This holds even after its comparator bit returns low.
- R4: The latch ignores a synchronised comparator value seen at a count below `blank_cnt`. The value is seen at count c, and the winding is off from count c+1, when c >= `blank_cnt`. A `blank_cnt` of 0 lets the comparator act from count 0 of the period.
- R5: Fast decay applies when `slow_sel[w]` is 0. The winding's phase legs follow `phase_in` and `inhib_n[w]` is 1 while the winding is on and 0 while it is off. Winding 0 uses `phase_in[1:0]` and drives `phase_out[1:0]`. Winding 1 uses `phase_in[3:2]` and drives `phase_out[3:2]`.
- R6: Slow decay applies when `slow_sel[w]` is 1. `inhib_n[w]` stays 1. The winding's two phase legs follow `phase_in` while the winding is on and are both 0 while it is off.
- R7: `sync_n` is 0 for exactly the first 16 counts of every period and 1 for the other 240.
- R8: While `drv_off` is 1, `phase_out` is 4'b0000 and `inhib_n` is 2'b00, whatever the other inputs are.
- R9: Each comparator bit passes through two flops. A level raised during count n, with blanking already over, leaves the winding on at counts n+1 and n+2 and switches it off from count n+3.
- R10: While `rst` is high, the counter holds at 0, `sync_n` is 0 and both windings are on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is 256 cycles |
| rst | input | 1 | Synchronous reset, active high |
| sense_trip | input | 2 | Comparator results, 1 = winding current at reference (bit w for winding w) |
| blank_cnt | input | 8 | Number of period counts during which comparator results are ignored |
| slow_sel | input | 2 | Decay style for each winding, 0 = fast, 1 = slow |
| drv_off | input | 1 | Forces all bridge outputs low when 1 |
| phase_in | input | 4 | Phase leg values from the step sequencer |
| phase_out | output | 4 | Phase leg drives to the bridges |
| inhib_n | output | 2 | Active-low inhibit drive for each winding |
| sync_n | output | 1 | Active-low pulse at the start of each period |

## Verification
The embedded properties check the following on every clock: the counter steps by one and wraps, `sync_n` ends its pulse at count 16, each trip latch is clear at count 0, it holds once set, and it cannot set inside the blanking window. They also tie each winding's latch state to its outputs in both decay styles and under disable. The bench scenarios must show the end-to-end timing that no single-cycle property covers. This includes the three-count latency from a comparator edge to the off state, the exact boundary count of the blanking window, and a short comparator pulse inside the window that leaves the winding on. The bench also covers the mixed decay-style combinations across both windings.

// File: rtl/dual_chop_pkg.sv
package dual_chop_pkg;

    localparam int NWIND = 2;

    typedef enum logic {
        DECAY_FAST = 1'b0,
        DECAY_SLOW = 1'b1
    } decay_e;

    // The two bridge legs that belong to one winding
    typedef struct packed {
        logic hi;
        logic lo;
    } leg_pair_t;

    // Everything one winding drives
    typedef struct packed {
        leg_pair_t legs;
        logic      inh_n;
    } wdrive_t;

    // Steers the chopping for one winding onto the inhibit line or the legs
    function automatic wdrive_t steer_winding(
        input leg_pair_t tbl,
        input decay_e    mode,
        input logic      on,
        input logic      kill
    );
        wdrive_t d;
        if (kill) begin
            d = '0;
        end else if (mode == DECAY_FAST) begin
            d.legs  = tbl;
            d.inh_n = on;
        end else begin
            d.legs  = on ? tbl : leg_pair_t'(2'b00);
            d.inh_n = 1'b1;
        end
        return d;
    endfunction

endpackage

// File: rtl/chop_timebase.sv
module chop_timebase #(
    parameter int CNT_W    = 8,
    parameter int SYNC_LEN = 16
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt,
    output logic             period_start,
    output logic             period_last,
    output logic             sync_n
);

    localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(SYNC_LEN);
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assign period_start = (cnt == '0);
    assign period_last  = (cnt == CNT_MAX);
    assign sync_n       = (cnt >= SYNC_END);

    AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (rst)
        period_last |=> (cnt == '0));                                    // R1
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !period_last |=> (cnt == CNT_W'($past(cnt) + 1'b1)));            // R1
    AST_SYNC_END: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_n) |-> (cnt == SYNC_END));                            // R7

endmodule

// File: rtl/chop_sense.sv
module chop_sense #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sense_raw,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] blank,
    input  logic             period_start,
    input  logic             period_last,
    output logic             tripped
);

    logic meta_q;
    logic sync_q;
    logic sense_ok;

    assign sense_ok = (cnt >= blank);

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= 1'b0;
            sync_q  <= 1'b0;
            tripped <= 1'b0;
        end else begin
            meta_q <= sense_raw;
            sync_q <= meta_q;
            if (period_last)
                tripped <= 1'b0;
            else if (sync_q && sense_ok)
                tripped <= 1'b1;
        end
    end

    AST_START_ON: assert property (@(posedge clk) disable iff (rst)
        period_start |-> !tripped);                                      // R2
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        (tripped && !period_last) |=> tripped);                          // R3
    AST_BLANK_MASK: assert property (@(posedge clk) disable iff (rst)
        (!tripped && !period_last && (cnt < blank)) |=> !tripped);       // R4

endmodule

// File: rtl/chop_steer.sv
module chop_steer
    import dual_chop_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               drv_off,
    input  logic [NWIND-1:0]   slow_sel,
    input  logic [NWIND-1:0]   trip,
    input  logic [2*NWIND-1:0] phase_in,
    output logic [2*NWIND-1:0] phase_out,
    output logic [NWIND-1:0]   inhib_n
);

    for (genvar w = 0; w < NWIND; w++) begin : g_wind
        wdrive_t drv;

        assign drv = steer_winding(leg_pair_t'(phase_in[2*w+1 -: 2]),
                                   decay_e'(slow_sel[w]),
                                   !trip[w], drv_off);
        assign phase_out[2*w+1 -: 2] = drv.legs;
        assign inhib_n[w]            = drv.inh_n;

        AST_FAST_CHOP: assert property (@(posedge clk) disable iff (rst)
            (!drv_off && !slow_sel[w]) |->
                (inhib_n[w] == !trip[w]) && (phase_out[2*w+1 -: 2] == phase_in[2*w+1 -: 2])); // R5
        AST_SLOW_CHOP: assert property (@(posedge clk) disable iff (rst)
            (!drv_off && slow_sel[w] && trip[w]) |->
                inhib_n[w] && (phase_out[2*w+1 -: 2] == 2'b00));                            // R6
        AST_KILL_LOW: assert property (@(posedge clk) disable iff (rst)
            drv_off |-> (!inhib_n[w] && (phase_out[2*w+1 -: 2] == 2'b00)));                 // R8
    end

endmodule

// File: rtl/dual_chop_top.sv
module dual_chop_top
    import dual_chop_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int SYNC_LEN = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NWIND-1:0]    sense_trip,
    input  logic [CNT_W-1:0]    blank_cnt,
    input  logic [NWIND-1:0]    slow_sel,
    input  logic                drv_off,
    input  logic [2*NWIND-1:0]  phase_in,
    output logic [2*NWIND-1:0]  phase_out,
    output logic [NWIND-1:0]    inhib_n,
    output logic                sync_n
);

    logic [CNT_W-1:0] cnt;
    logic             period_start;
    logic             period_last;
    logic [NWIND-1:0] trip;

    chop_timebase #(.CNT_W(CNT_W), .SYNC_LEN(SYNC_LEN)) u_tb (
        .clk          (clk),
        .rst          (rst),
        .cnt          (cnt),
        .period_start (period_start),
        .period_last  (period_last),
        .sync_n       (sync_n)
    );

    for (genvar w = 0; w < NWIND; w++) begin : g_sense
        chop_sense #(.CNT_W(CNT_W)) u_sense (
            .clk          (clk),
            .rst          (rst),
            .sense_raw    (sense_trip[w]),
            .cnt          (cnt),
            .blank        (blank_cnt),
            .period_start (period_start),
            .period_last  (period_last),
            .tripped      (trip[w])
        );
    end

    chop_steer u_steer (
        .clk       (clk),
        .rst       (rst),
        .drv_off   (drv_off),
        .slow_sel  (slow_sel),
        .trip      (trip),
        .phase_in  (phase_in),
        .phase_out (phase_out),
        .inhib_n   (inhib_n)
    );

    AST_RESET_ON: assert property (@(posedge clk)
        rst |=> ((cnt == '0) && (trip == '0)));                          // R10

endmodule

// File: tb/dual_chop_top_tb_top.sv
module dual_chop_top_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] sense_trip;
    logic [7:0] blank_cnt;
    logic [1:0] slow_sel;
    logic       drv_off;
    logic [3:0] phase_in;
    logic [3:0] phase_out;
    logic [1:0] inhib_n;
    logic       sync_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dual_chop_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .sense_trip (sense_trip),
        .blank_cnt  (blank_cnt),
        .slow_sel   (slow_sel),
        .drv_off    (drv_off),
        .phase_in   (phase_in),
        .phase_out  (phase_out),
        .inhib_n    (inhib_n),
        .sync_n     (sync_n)
    );

    // Fields: off | slow[1:0] | sense[1:0] | phase_in | exp phase_out | exp inhib_n
    // Sampled at count 100 with blank 0; R5 R6 R8
    localparam logic [14:0] VEC [10] = '{
        15'b0_00_00_0101_0101_11,
        15'b0_00_11_0101_0101_00,
        15'b0_11_11_0101_0000_11,
        15'b0_11_00_1010_1010_11,
        15'b0_01_01_1010_1000_11,
        15'b0_01_10_0110_0110_01,
        15'b0_10_11_1001_0001_10,
        15'b1_00_00_0101_0000_00,
        15'b1_11_11_1010_0000_00,
        15'b0_10_01_0110_0110_10
    };

    logic [14:0] v;
    int lo_cnt;
    int hi_cnt;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Wait for the next period start, then to count n, sampling at a falling edge
    task automatic goto_cnt(input int n);
        @(negedge sync_n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        sense_trip = 2'b11;
        blank_cnt  = 8'd0;
        slow_sel   = 2'b00;
        drv_off    = 1'b0;
        phase_in   = 4'b0101;
        step(4);
        // R10: reset holds sync low and both windings on despite trips
        check("R10 sync_n", sync_n, 0);
        check("R10 inhib_n", inhib_n, 2'b11);
        check("R10 phase_out", phase_out, 4'b0101);
        sense_trip = 2'b00;
        rst = 1'b0;

        // R1 and R7: pulse width and period length
        goto_cnt(0);
        lo_cnt = 0;
        while (sync_n == 1'b0 && lo_cnt < 1000) begin lo_cnt++; @(negedge clk); end
        hi_cnt = 0;
        while (sync_n == 1'b1 && hi_cnt < 1000) begin hi_cnt++; @(negedge clk); end
        check("R7 sync low width", lo_cnt, 16);
        check("R1 period length", lo_cnt + hi_cnt, 256);

        // Table walk: R5 R6 R8
        for (int i = 0; i < 10; i++) begin
            v = VEC[i];
            drv_off    = v[14];
            slow_sel   = v[13:12];
            sense_trip = v[11:10];
            phase_in   = v[9:6];
            goto_cnt(100);
            check("R5/R6/R8 table phase_out", phase_out, v[5:2]);
            check("R5/R6/R8 table inhib_n", inhib_n, v[1:0]);
        end

        // R2 and R4: both on at count 0, zero blanking acts from the first count
        drv_off    = 1'b0;
        slow_sel   = 2'b00;
        phase_in   = 4'b0101;
        blank_cnt  = 8'd0;
        sense_trip = 2'b01;
        goto_cnt(0);
        check("R2 both on at start", inhib_n, 2'b11);
        step(1);
        check("R2 independent off / R4 zero blank", inhib_n, 2'b10);

        // R4: blanking boundary with comparator held high
        blank_cnt = 8'd40;
        goto_cnt(40);
        check("R4 on at blank count", inhib_n[0], 1);
        step(1);
        check("R4 off after blank count", inhib_n[0], 0);

        // R4: short pulse inside the blanking window is ignored
        sense_trip = 2'b00;
        goto_cnt(5);
        sense_trip = 2'b01;
        step(10);
        sense_trip = 2'b00;
        step(85);
        check("R4 pulse in blanking ignored", inhib_n[0], 1);

        // R9 latency, R3 hold, R2 clear at next period
        blank_cnt = 8'd0;
        goto_cnt(100);
        sense_trip = 2'b01;
        step(1);
        check("R9 on at n+1", inhib_n[0], 1);
        step(1);
        check("R9 on at n+2", inhib_n[0], 1);
        step(1);
        check("R9 off at n+3", inhib_n[0], 0);
        sense_trip = 2'b00;
        step(97);
        check("R3 stays off after sense drops", inhib_n[0], 0);
        step(56);
        check("R2 on again at next period", inhib_n[0], 1);

        // R6: slow decay legs chopped, inhibit held, on the other winding
        slow_sel   = 2'b10;
        phase_in   = 4'b1001;
        sense_trip = 2'b10;
        goto_cnt(0);
        check("R6 legs driven at start", phase_out, 4'b1001);
        step(1);
        check("R6 legs cut after trip", phase_out, 4'b0001);
        check("R6 inhibit held", inhib_n, 2'b11);

        // R8: disable mid-period
        drv_off = 1'b1;
        step(1);
        check("R8 outputs low", {phase_out, inhib_n}, 6'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule